// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host processor byte- or word-wide access to a network card's local packet memory through one data port. The host loads a 16-bit pointer and a 16-bit transfer length, each as two byte-wide register writes. Each access to the data port then reads or writes the memory at the pointer, moves the pointer forward, and takes the transfer size off the length. When the pointer reaches the receive ring's stop page, it folds back to the ring's first page. When the length runs out, a sticky completion flag is raised.

The host reaches every control field through a small byte-wide register interface. This covers the command byte, the two ring page bounds, the data-width selector, the status byte holding the completion flag, and the pointer and length halves. Reads of the pointer and length offsets return the live values, so the host can follow a transfer. The packet memory is a window of whole 256-byte pages. Accesses that land outside it leave memory untouched and read as all ones.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the pointer, the length, both ring page registers, the command byte and the width selector read as zero, and the completion flag is low.
- R2: The pointer and the length are each loaded through a low-byte offset (0x8 pointer, 0xA length) and a high-byte offset (0x9 pointer, 0xB length). Each write replaces only its own byte. Reading the same offsets returns the current pointer and the remaining length.
- R3: With bit 0 of the width selector (offset 0x4) clear, one access moves the single byte at the pointer. A write takes it from data bits 7:0. A read returns it in bits 7:0, with bits 15:8 zero. The pointer advances by 1.
- R4: With that bit set, one access moves two bytes starting at the pointer with bit 0 forced to zero, in little-endian order (even byte on bits 7:0). The pointer advances by 2 from its stored value.
- R5: If the advanced pointer equals the stop page (offset 0x2) times 256, it is replaced by the first page (offset 0x1) times 256.
- R6: An access with a nonzero length reduces the length by the transfer size. If the length was no larger than the transfer size, it becomes zero and the completion flag is set. The flag is status bit 6 (value 0x40 at offset 0x3) and is driven on `done_o`.
- R7: While the length is zero, a data-port access changes neither memory, the pointer, the length nor the flag, and a read returns 0xFFFF.
- R8: Writing the command byte (offset 0x0) with bit 3 or bit 4 set and bit 0 clear while the length is zero sets the completion flag at once. Any other command write leaves the flag unchanged.
- R9: The memory window is `WIN_PAGES` pages starting at page `WIN_BASE_PAGE` (0x0400 to 0x07FF by default). An access whose effective address is outside the window writes nothing and reads 0xFFFF, but still advances the pointer and the length.
- R10: Writing the status byte with bit 6 set clears the completion flag, and writing it with bit 6 clear leaves the flag alone. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| dp_wr | input | 1 | Data-port write access (wins over `dp_rd`) |
| dp_rd | input | 1 | Data-port read access |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data at the current pointer (combinational) |
| done_o | output | 1 | Completion flag |

## Verification
The main transfer path is swept over both widths, several lengths from one byte to seven, and start pointers that are even, odd, at the window base and just below the stop page. Together these separate plain stepping, the final short transfer, the fold back at the stop page and word accesses from an odd pointer. Extra accesses after the length is exhausted show whether a design keeps moving the pointer or touching memory when it should be idle. A transfer that straddles the lower window edge tells ignored out-of-window bytes apart from a stalled pointer. A word write read back as bytes pins down the byte order. Command writes with every combination of the read, write and stop bits, at zero and nonzero lengths, separate a proper zero-length completion from a flag raised by any command.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;
  localparam int HALF_W = 8;
  localparam int PTR_W  = 2 * HALF_W;

  // register offsets
  localparam logic [3:0] OFS_CMD     = 4'h0;
  localparam logic [3:0] OFS_FIRST   = 4'h1;
  localparam logic [3:0] OFS_LAST    = 4'h2;
  localparam logic [3:0] OFS_STAT    = 4'h3;
  localparam logic [3:0] OFS_CFG     = 4'h4;
  localparam logic [3:0] OFS_ADDR_LO = 4'h8;
  localparam logic [3:0] OFS_ADDR_HI = 4'h9;
  localparam logic [3:0] OFS_CNT_LO  = 4'hA;
  localparam logic [3:0] OFS_CNT_HI  = 4'hB;

  // bit positions
  localparam int CMD_HALT_BIT  = 0;
  localparam int CMD_RD_BIT    = 3;
  localparam int CMD_WR_BIT    = 4;
  localparam int STAT_DONE_BIT = 6;
  localparam int CFG_WORD_BIT  = 0;

  typedef struct packed {
    logic addr_lo;
    logic addr_hi;
    logic cnt_lo;
    logic cnt_hi;
  } rdma_load_t;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } rdma_acc_e;
endpackage

// File: rtl/rdma_ptr.sv
`timescale 1ns/1ps
module rdma_ptr
  import rdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rdma_load_t       ld,
  input  logic [HALF_W-1:0] wbyte,
  input  logic             adv,
  input  logic             word_mode,
  input  logic [HALF_W-1:0] ring_first,
  input  logic [HALF_W-1:0] ring_last,
  output logic [PTR_W-1:0] addr_q,
  output logic [PTR_W-1:0] cnt_q,
  output logic             cnt_zero,
  output logic             last_xfer
);
  logic [PTR_W-1:0] step;
  logic [PTR_W-1:0] addr_inc;
  logic [PTR_W-1:0] addr_adv;
  logic [PTR_W-1:0] addr_d;
  logic [PTR_W-1:0] cnt_d;
  logic             addr_en;
  logic             cnt_en;

  always_comb begin
    step      = word_mode ? PTR_W'(2) : PTR_W'(1);
    addr_inc  = addr_q + step;
    addr_adv  = (addr_inc == {ring_last, {HALF_W{1'b0}}}) ?
                {ring_first, {HALF_W{1'b0}}} : addr_inc;
    cnt_zero  = (cnt_q == '0);
    last_xfer = adv && (cnt_q <= step);
  end

  // a host write to either half overrides the advance for that register
  always_comb begin
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (ld.addr_lo || ld.addr_hi) begin
      addr_en = 1'b1;
      if (ld.addr_lo) addr_d[HALF_W-1:0]     = wbyte;
      if (ld.addr_hi) addr_d[PTR_W-1:HALF_W] = wbyte;
    end else if (adv) begin
      addr_en = 1'b1;
      addr_d  = addr_adv;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (ld.cnt_lo || ld.cnt_hi) begin
      cnt_en = 1'b1;
      if (ld.cnt_lo) cnt_d[HALF_W-1:0]     = wbyte;
      if (ld.cnt_hi) cnt_d[PTR_W-1:HALF_W] = wbyte;
    end else if (adv) begin
      cnt_en = 1'b1;
      cnt_d  = last_xfer ? '0 : (cnt_q - step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rdma_ctrl.sv
`timescale 1ns/1ps
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  input  logic              cnt_zero,
  input  logic              xfer_done,
  output logic [HALF_W-1:0] cmd_q,
  output logic [HALF_W-1:0] ring_first_q,
  output logic [HALF_W-1:0] ring_last_q,
  output logic              word_mode_q,
  output logic              done_q
);
  logic wr_cmd, wr_first, wr_last, wr_stat, wr_cfg;
  logic zero_len, done_set, done_clr, done_d;

  always_comb begin
    wr_cmd   = reg_wr && (reg_addr == OFS_CMD);
    wr_first = reg_wr && (reg_addr == OFS_FIRST);
    wr_last  = reg_wr && (reg_addr == OFS_LAST);
    wr_stat  = reg_wr && (reg_addr == OFS_STAT);
    wr_cfg   = reg_wr && (reg_addr == OFS_CFG);
    zero_len = wr_cmd && cnt_zero && !reg_wdata[CMD_HALT_BIT] &&
               (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
    done_set = xfer_done || zero_len;
    done_clr = wr_stat && reg_wdata[STAT_DONE_BIT];
    if (done_set)      done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
    else               done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (wr_cmd) begin
      cmd_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_first_q <= '0;
    end else if (wr_first) begin
      ring_first_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_last_q <= '0;
    end else if (wr_last) begin
      ring_last_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_mode_q <= 1'b0;
    end else if (wr_cfg) begin
      word_mode_q <= reg_wdata[CFG_WORD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_set || done_clr) begin
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/rdma_mem.sv
`timescale 1ns/1ps
module rdma_mem
  import rdma_pkg::*;
#(
  parameter int WIN_BASE_PAGE = 4,
  parameter int WIN_PAGES     = 4
) (
  input  logic             clk,
  input  logic [PTR_W-1:0] eff_addr,
  input  logic             we,
  input  logic             word_mode,
  input  logic [PTR_W-1:0] wdata,
  output logic             in_win,
  output logic [PTR_W-1:0] rdata
);
  localparam int PAGE_BYTES = 1 << HALF_W;
  localparam int DEPTH      = WIN_PAGES * PAGE_BYTES;
  localparam int IW         = $clog2(DEPTH);
  localparam int LANES      = PTR_W / HALF_W;
  localparam logic [PTR_W:0]   WIN_LO = (PTR_W+1)'(WIN_BASE_PAGE * PAGE_BYTES);
  localparam logic [PTR_W:0]   WIN_HI = (PTR_W+1)'((WIN_BASE_PAGE + WIN_PAGES) * PAGE_BYTES);
  localparam logic [PTR_W-1:0] BASE16 = PTR_W'(WIN_BASE_PAGE * PAGE_BYTES);

  logic [HALF_W-1:0] mem [DEPTH];
  logic [IW-1:0]     idx;
  logic [IW-1:0]     lane_idx [LANES];
  logic              lane_en  [LANES];

  always_comb begin
    in_win = ({1'b0, eff_addr} >= WIN_LO) && ({1'b0, eff_addr} < WIN_HI);
    idx    = IW'(eff_addr - BASE16);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      lane_idx[g] = idx + IW'(g);
      lane_en[g]  = we && in_win && ((g == 0) || word_mode);
      rdata[g*HALF_W +: HALF_W] = mem[lane_idx[g]];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_en[k]) begin
        mem[lane_idx[k]] <= wdata[k*HALF_W +: HALF_W];
      end
    end
  end
endmodule

// File: rtl/rdma_port_engine.sv
`timescale 1ns/1ps
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int WIN_BASE_PAGE = 4,
  parameter int WIN_PAGES     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_wr,
  input  logic        dp_rd,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  output logic        done_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  rdma_acc_e         acc;
  rdma_load_t        ld;
  logic              adv;
  logic [PTR_W-1:0]  addr_q, cnt_q, eff_addr, mem_rdata;
  logic              cnt_zero, last_xfer, in_win, mem_we;
  logic [HALF_W-1:0] cmd_q, ring_first, ring_last;
  logic              word_mode, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    if (dp_wr)      acc = ACC_WRITE;
    else if (dp_rd) acc = ACC_READ;
    else            acc = ACC_NONE;
    ld.addr_lo = reg_wr && (reg_addr == OFS_ADDR_LO);
    ld.addr_hi = reg_wr && (reg_addr == OFS_ADDR_HI);
    ld.cnt_lo  = reg_wr && (reg_addr == OFS_CNT_LO);
    ld.cnt_hi  = reg_wr && (reg_addr == OFS_CNT_HI);
    adv        = (acc != ACC_NONE) && !cnt_zero;
    mem_we     = (acc == ACC_WRITE) && !cnt_zero;
    eff_addr   = word_mode ? {addr_q[PTR_W-1:1], 1'b0} : addr_q;
  end

  rdma_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ld        (ld),
    .wbyte     (reg_wdata),
    .adv       (adv),
    .word_mode (word_mode),
    .ring_first(ring_first),
    .ring_last (ring_last),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .cnt_zero  (cnt_zero),
    .last_xfer (last_xfer)
  );

  rdma_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .cnt_zero    (cnt_zero),
    .xfer_done   (last_xfer),
    .cmd_q       (cmd_q),
    .ring_first_q(ring_first),
    .ring_last_q (ring_last),
    .word_mode_q (word_mode),
    .done_q      (done)
  );

  rdma_mem #(
    .WIN_BASE_PAGE(WIN_BASE_PAGE),
    .WIN_PAGES    (WIN_PAGES)
  ) u_mem (
    .clk      (clk),
    .eff_addr (eff_addr),
    .we       (mem_we),
    .word_mode(word_mode),
    .wdata    (dp_wdata),
    .in_win   (in_win),
    .rdata    (mem_rdata)
  );

  always_comb begin
    if (cnt_zero || !in_win) dp_rdata = '1;
    else if (word_mode)      dp_rdata = mem_rdata;
    else                     dp_rdata = {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CMD:     reg_rdata = cmd_q;
      OFS_FIRST:   reg_rdata = ring_first;
      OFS_LAST:    reg_rdata = ring_last;
      OFS_STAT:    reg_rdata = HALF_W'(done) << STAT_DONE_BIT;
      OFS_CFG:     reg_rdata = HALF_W'(word_mode) << CFG_WORD_BIT;
      OFS_ADDR_LO: reg_rdata = addr_q[HALF_W-1:0];
      OFS_ADDR_HI: reg_rdata = addr_q[PTR_W-1:HALF_W];
      OFS_CNT_LO:  reg_rdata = cnt_q[HALF_W-1:0];
      OFS_CNT_HI:  reg_rdata = cnt_q[PTR_W-1:HALF_W];
      default:     reg_rdata = '0;
    endcase
  end

  assign done_o = done;
endmodule

// File: rtl/rdma_port_engine_chk.sv
`timescale 1ns/1ps
module rdma_port_engine_chk
  import rdma_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        dp_wr,
  input logic        dp_rd,
  input logic [15:0] cur_addr,
  input logic [15:0] cur_cnt,
  input logic        word_mode,
  input logic [7:0]  ring_first,
  input logic [7:0]  ring_last,
  input logic        done
);
  logic        acc, ld_addr, ld_cnt, wr_cmd, wr_stat, wrap_hit;
  logic [15:0] step, inc_addr;

  always_comb begin
    acc      = dp_wr || dp_rd;
    ld_addr  = reg_wr && (reg_addr == OFS_ADDR_LO || reg_addr == OFS_ADDR_HI);
    ld_cnt   = reg_wr && (reg_addr == OFS_CNT_LO || reg_addr == OFS_CNT_HI);
    wr_cmd   = reg_wr && (reg_addr == OFS_CMD);
    wr_stat  = reg_wr && (reg_addr == OFS_STAT);
    step     = word_mode ? 16'd2 : 16'd1;
    inc_addr = cur_addr + step;
    wrap_hit = (inc_addr == {ring_last, 8'h00});
  end

  // R7: idle length freezes pointer and length
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_cnt == 16'd0 && !ld_addr && !ld_cnt) |=> ($stable(cur_addr) && $stable(cur_cnt)));

  // R6: length reduced by the transfer size
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_cnt > step && !ld_cnt) |=> (cur_cnt == $past(cur_cnt) - $past(step)));

  // R6: last transfer empties the length and raises the flag
  assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_cnt != 16'd0 && cur_cnt <= step && !ld_cnt) |=> (cur_cnt == 16'd0 && done));

  // R5: pointer steps forward, folding at the stop page
  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_cnt != 16'd0 && !ld_addr) |=>
      (cur_addr == ($past(wrap_hit) ? {$past(ring_first), 8'h00} : $past(inc_addr))));

  // R8: zero-length command completes at once
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cur_cnt == 16'd0 && !reg_wdata[CMD_HALT_BIT] &&
     (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT])) |=> done);

  // R10: write-one clears the flag when nothing sets it
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[STAT_DONE_BIT] && !(acc && cur_cnt != 16'd0)) |=> !done);

  // R6, R8: the flag only rises for a finishing access or a command write
  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((acc && cur_cnt != 16'd0) || wr_cmd));
endmodule

bind rdma_port_engine rdma_port_engine_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dp_wr     (dp_wr),
  .dp_rd     (dp_rd),
  .cur_addr  (addr_q),
  .cur_cnt   (cnt_q),
  .word_mode (word_mode),
  .ring_first(ring_first),
  .ring_last (ring_last),
  .done      (done)
);

// File: tb/rdma_port_engine_tb_top.sv
`timescale 1ns/1ps
module rdma_port_engine_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        dp_wr;
  logic        dp_rd;
  logic [15:0] dp_wdata;
  logic [15:0] dp_rdata;
  logic        done_o;

  int n_chk;
  int n_bad;

  // reference state
  logic [15:0] m_addr, m_cnt;
  logic [7:0]  m_first, m_last;
  logic        m_word, m_done;
  logic [7:0]  exp_mem [1024];

  rdma_port_engine dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .dp_wr    (dp_wr),
    .dp_rd    (dp_rd),
    .dp_wdata (dp_wdata),
    .dp_rdata (dp_rdata),
    .done_o   (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  function automatic bit in_win(input logic [15:0] e);
    return (e >= 16'h0400) && (e < 16'h0800);
  endfunction

  task automatic set_addr(input logic [15:0] a);
    reg_write(4'h8, a[7:0]);
    reg_write(4'h9, a[15:8]);
    m_addr = a;
  endtask

  task automatic set_cnt(input logic [15:0] c);
    reg_write(4'hA, c[7:0]);
    reg_write(4'hB, c[15:8]);
    m_cnt = c;
  endtask

  task automatic set_mode(input logic w);
    reg_write(4'h4, {7'd0, w});
    m_word = w;
  endtask

  task automatic set_ring(input logic [7:0] f, input logic [7:0] l);
    reg_write(4'h1, f);
    reg_write(4'h2, l);
    m_first = f;
    m_last  = l;
  endtask

  task automatic clr_done();
    reg_write(4'h3, 8'h40);
    m_done = 1'b0;
  endtask

  task automatic m_step(input bit is_wr, input logic [15:0] d);
    logic [15:0] e, st;
    if (m_cnt != 16'd0) begin
      e  = m_word ? {m_addr[15:1], 1'b0} : m_addr;
      st = m_word ? 16'd2 : 16'd1;
      if (is_wr && in_win(e)) begin
        exp_mem[int'(e) - 1024] = d[7:0];
        if (m_word) exp_mem[int'(e) - 1023] = d[15:8];
      end
      m_addr = m_addr + st;
      if (m_addr == {m_last, 8'h00}) m_addr = {m_first, 8'h00};
      if (m_cnt <= st) begin
        m_cnt  = 16'd0;
        m_done = 1'b1;
      end else begin
        m_cnt = m_cnt - st;
      end
    end
  endtask

  task automatic dp_write(input logic [15:0] d);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk);
    dp_wr = 1'b0;
    m_step(1'b1, d);
  endtask

  task automatic dp_read(input string tag);
    logic [15:0] e, exp;
    @(negedge clk);
    dp_rd = 1'b1;
    #2;
    e = m_word ? {m_addr[15:1], 1'b0} : m_addr;
    if (m_cnt == 16'd0 || !in_win(e)) exp = 16'hFFFF;
    else if (m_word) exp = {exp_mem[int'(e) - 1023], exp_mem[int'(e) - 1024]};
    else exp = {8'h00, exp_mem[int'(e) - 1024]};
    check(tag, int'(dp_rdata), int'(exp));
    @(negedge clk);
    dp_rd = 1'b0;
    m_step(1'b0, 16'h0);
  endtask

  task automatic check_state(input string t_addr, input string t_cnt, input string t_done);
    logic [7:0] lo, hi, st;
    reg_read(4'h8, lo);
    reg_read(4'h9, hi);
    check(t_addr, int'({hi, lo}), int'(m_addr));
    reg_read(4'hA, lo);
    reg_read(4'hB, hi);
    check(t_cnt, int'({hi, lo}), int'(m_cnt));
    reg_read(4'h3, st);
    check(t_done, int'(st), m_done ? 32'h40 : 32'h0);
    check(t_done, int'(done_o), int'(m_done));
  endtask

  initial begin
    logic [7:0] rv;
    int starts [4];
    int lens   [6];
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = 8'h00;
    dp_wr = 1'b0; dp_rd = 1'b0; dp_wdata = 16'h0;
    m_addr = 16'h0; m_cnt = 16'h0; m_first = 8'h0; m_last = 8'h0;
    m_word = 1'b0; m_done = 1'b0;
    for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_state("R1 addr", "R1 count", "R1 flag");
    reg_read(4'h0, rv); check("R1 cmd", int'(rv), 0);
    reg_read(4'h1, rv); check("R1 first page", int'(rv), 0);
    reg_read(4'h2, rv); check("R1 stop page", int'(rv), 0);
    reg_read(4'h4, rv); check("R1 width", int'(rv), 0);

    // R2: half-register loads
    reg_write(4'h8, 8'h34); m_addr = 16'h0034;
    check_state("R2 addr lo", "R2 count", "R2 flag");
    reg_write(4'h9, 8'h12); m_addr = 16'h1234;
    check_state("R2 addr hi", "R2 count", "R2 flag");
    reg_write(4'h8, 8'h56); m_addr = 16'h1256;
    check_state("R2 addr lo keeps hi", "R2 count", "R2 flag");
    reg_write(4'hB, 8'hA5); m_cnt = 16'hA500;
    check_state("R2 addr", "R2 count hi", "R2 flag");
    reg_write(4'hA, 8'h0F); m_cnt = 16'hA50F;
    check_state("R2 addr", "R2 count lo keeps hi", "R2 flag");

    // R3/R4: byte order
    set_ring(8'h04, 8'h08);
    set_mode(1'b1); set_addr(16'h0500); set_cnt(16'd2);
    dp_write(16'hA1B2);
    check_state("R4 addr step", "R6 count", "R6 flag");
    set_mode(1'b0); set_addr(16'h0500); set_cnt(16'd2);
    dp_read("R4 little-endian even byte");
    dp_read("R4 little-endian odd byte");
    check("R4 even byte", int'(exp_mem[256]), 32'hB2);
    clr_done();

    // R3..R7: sweep of width, start and length
    starts = '{32'h0400, 32'h0401, 32'h07F8, 32'h07F9};
    lens   = '{1, 2, 3, 4, 5, 7};
    for (int w = 0; w < 2; w++) begin
      for (int si = 0; si < 4; si++) begin
        for (int li = 0; li < 6; li++) begin
          int nacc;
          nacc = w ? (lens[li] + 1) / 2 : lens[li];
          clr_done();
          set_mode(w[0]);
          set_addr(16'(starts[si]));
          set_cnt(16'(lens[li]));
          for (int k = 0; k < nacc + 2; k++) begin
            dp_write(16'(((si * 7 + li * 13 + k * 29 + w * 3) & 16'hFF) * 16'h0101 + 16'h0100 * k));
          end
          check_state(w ? "R4 R5 addr after writes" : "R3 R5 addr after writes",
                      "R6 count after writes", "R6 flag after writes");
          clr_done();
          set_addr(16'(starts[si]));
          set_cnt(16'(lens[li]));
          for (int k = 0; k < nacc; k++) begin
            dp_read(w ? "R4 word read" : "R3 byte read");
          end
          dp_read("R7 read with zero length");
          check_state("R7 addr frozen", "R7 count held", "R6 flag after reads");
        end
      end
    end

    // R9: transfer across the lower window edge
    clr_done();
    set_ring(8'h00, 8'hFF);
    set_mode(1'b0);
    set_addr(16'h03FE); set_cnt(16'd4);
    for (int k = 0; k < 4; k++) dp_write(16'(8'h70 + k));
    check_state("R9 addr still advances", "R9 count still drops", "R9 flag");
    clr_done();
    set_addr(16'h03FE); set_cnt(16'd4);
    for (int k = 0; k < 4; k++) dp_read("R9 window read");
    check("R9 in-window byte", int'(exp_mem[1]), 32'h73);

    // R8: zero-length commands
    clr_done(); set_cnt(16'd0);
    reg_write(4'h0, 8'h0A);
    check("R8 read command zero length", int'(done_o), 1);
    clr_done();
    reg_write(4'h0, 8'h12);
    check("R8 write command zero length", int'(done_o), 1);
    clr_done();
    reg_write(4'h0, 8'h09);
    check("R8 halt bit blocks completion", int'(done_o), 0);
    reg_write(4'h0, 8'h22);
    check("R8 no transfer bit", int'(done_o), 0);
    set_cnt(16'd5);
    reg_write(4'h0, 8'h0A);
    check("R8 nonzero length", int'(done_o), 0);
    reg_read(4'h0, rv);
    check("R8 command readback", int'(rv), 32'h0A);

    // R10: clear rules
    set_cnt(16'd0);
    reg_write(4'h0, 8'h08);
    reg_write(4'h3, 8'hBF);
    check("R10 write without bit 6 keeps flag", int'(done_o), 1);
    reg_write(4'h3, 8'h40);
    check("R10 write-one clears flag", int'(done_o), 0);
    set_mode(1'b0); set_addr(16'h0600); set_cnt(16'd1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h3; reg_wdata = 8'h40;
    dp_wr = 1'b1; dp_wdata = 16'h005A;
    @(negedge clk);
    reg_wr = 1'b0; dp_wr = 1'b0;
    m_step(1'b1, 16'h005A);
    check_state("R10 addr", "R10 count", "R10 set beats clear");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule